// File: doc/BRIEF.md
# Timer-Compare Output Event Scheduler

The scheduler holds up to eight pending output commands, each paired with a 16-bit target time. Every stored entry carries its own timer selection and is checked against one of two free-running timer values. An external strobe marks each timer increment, and the comparison runs only in that cycle. When an entry's stored time equals its selected timer, the entry fires. Firing can set or clear one or two output pins, pulse one of four software-timer flags, pulse a request to reset the second timer, or pulse an A/D start request. It can also raise one of two interrupt pulses.

Software loads a command in two steps. It first writes a command byte and then writes the time word. A small write sequencer with two states handles this. `WR_IDLE` moves to `WR_CMD` when a command byte is written. `WR_CMD` returns to `WR_IDLE` when a time word is written, and that same write commits the entry. A further command byte while in `WR_CMD` replaces the pending byte and stays in `WR_CMD`.

Entries can be locked so that they fire on every match, which produces periodic events. A clear strobe empties the whole table, locked entries included. An event status byte records what has fired. Reading it clears it, and a preset write loads both the status byte and the pin levels without raising interrupts.

Top module: `evsched_top`

## Requirements
- R1: Command byte layout: bit 7 is lock, bit 6 selects the timer (1 = `timer2`, 0 = `timer1`), bit 5 chooses set (1) or clear (0), bit 4 requests an interrupt, and bits 3:0 hold the channel code. A stored entry fires in a cycle where `cmp_en` is high and its time equals its selected timer. Its effects appear on the outputs one clock later.
- R2: Channel codes 0 to 5 drive pin 0 to pin 5 alone. Code 6 drives pins 0 and 1 together, and code 7 drives pins 2 and 3 together. A pin holds its level until an entry or a preset write changes it.
- R3: Codes 8 to 11 pulse `swt_o` bit (code − 8) for one cycle. Code 14 pulses `t2_reset_o` and code 15 pulses `adc_start_o`. Codes 12 and 13 drive no output.
- R4: An entry is kept after firing only when its lock bit was 1 and `lock_en` was high at commit. Any other entry is freed when it fires.
- R5: `irq_pin_o` pulses after any fired entry with the interrupt bit set and a code from 0 to 7. `irq_other_o` pulses for the same condition with a code from 8 to 15.
- R6: The status byte is sticky. Bits 0 to 5 are set by fired entries touching pins 0 to 5, bit 6 by code 14, and bit 7 by code 15.
- R7: `stat_rd` clears the status byte on the next edge. Events firing in the same cycle are still recorded.
- R8: `stat_wr` loads `stat_wdata` into the status byte and `stat_wdata[5:0]` onto the pins, and it raises no interrupt.
- R9: `tbl_clr` removes every entry, locked ones included, and drops any commit in the same cycle.
- R10: `full_o` is high while all 8 entries are occupied. A commit while full is discarded.
- R11: An entry is committed only by a time word that follows a command byte. A time word with no pending command is ignored.
- R12: A new entry takes the lowest free slot. When fired entries disagree on a pin in the same cycle, the lowest slot wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| time_we | input | 1 | Time word write strobe (commits) |
| time_word | input | 16 | Target time |
| lock_en | input | 1 | Global enable for the lock bit |
| tbl_clr | input | 1 | Empty the whole table |
| cmp_en | input | 1 | Timer increment strobe; comparison cycle |
| timer1 | input | 16 | First timer value |
| timer2 | input | 16 | Second timer value |
| stat_rd | input | 1 | Status read strobe (clears status) |
| stat_wr | input | 1 | Status and pin preset strobe |
| stat_wdata | input | 8 | Preset value |
| pins_o | output | 6 | Output pin levels |
| irq_pin_o | output | 1 | Pin-event interrupt pulse |
| irq_other_o | output | 1 | Other-event interrupt pulse |
| swt_o | output | 4 | Software timer flag pulses |
| t2_reset_o | output | 1 | Second-timer reset request pulse |
| adc_start_o | output | 1 | A/D start request pulse |
| full_o | output | 1 | All entries occupied |
| status_o | output | 8 | Event status byte |

## Verification
The bench sends two entries with opposite actions on one pin to the same tick, in both slot orders. A design that resolved the conflict in write order, or let the higher slot win, would leave the pin at the wrong level in one of the two runs. It fires a locked entry, clears the pins with a preset, and fires the entry again, so a design that freed locked entries or ignored `lock_en` shows a missing pin edge. It also sends time words with no pending command, writes into a full table, and fires a locked entry's time after a table clear; a sloppy commit path or clear would produce stray pin or status events there. Finally, it mixes non-pin codes (including the unflagged ones) with interrupt bits, which exposes a design that routed interrupts to the wrong output or let status bits leak.

// File: rtl/evsched_pkg.sv
package evsched_pkg;
    localparam int PIN_CNT = 6;
    localparam int SWT_CNT = 4;
    localparam int STAT_W  = PIN_CNT + 2;

    // Command byte: field order is the decoded bit layout (MSB first).
    typedef struct packed {
        logic       keep;      // lock request
        logic       use_t2;    // compare against timer2
        logic       drive_hi;  // set (1) / clear (0)
        logic       want_irq;  // interrupt request
        logic [3:0] chan;      // channel code
    } cmd_t;

    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_CMD  = 1'b1
    } wr_state_e;

    function automatic logic [PIN_CNT-1:0] pin_mask(input logic [3:0] code);
        logic [PIN_CNT-1:0] m;
        m = '0;
        if (code < 4'd6)       m[code[2:0]] = 1'b1;
        else if (code == 4'd6) m = 6'b000011;
        else if (code == 4'd7) m = 6'b001100;
        return m;
    endfunction
endpackage

// File: rtl/evsched_wr.sv
module evsched_wr
    import evsched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic time_we,
    output logic commit,
    output cmd_t held_cmd
);
    wr_state_e state_q, state_d;
    cmd_t      cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= cmd_t'(cmd_byte);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (cmd_we) state_d = WR_CMD;
            WR_CMD: begin
                if (cmd_we)       state_d = WR_CMD;
                else if (time_we) state_d = WR_IDLE;
            end
            default: state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        commit   = (state_q == WR_CMD) && time_we;
        held_cmd = cmd_q;
    end

    // R11
    commit_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_IDLE && !cmd_we) |=> (state_q == WR_IDLE));
endmodule

// File: rtl/evsched_table.sv
module evsched_table
    import evsched_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int TIME_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  cmd_t              cmd_in,
    input  logic [TIME_W-1:0] time_in,
    input  logic              lock_en,
    input  logic              clr,
    input  logic              cmp_en,
    input  logic [TIME_W-1:0] timer1,
    input  logic [TIME_W-1:0] timer2,
    output logic [N_SLOTS-1:0] fire,
    output cmd_t              slot_cmd [N_SLOTS],
    output logic              full
);
    logic [N_SLOTS-1:0] valid_q, alloc_oh, take, keep_v, retire;

    assign full = &valid_q;

    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (!valid_q[i] && !found) begin
                alloc_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    assign take   = (commit && !full && !clr) ? alloc_oh : '0;
    assign retire = fire & ~keep_v;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        cmd_t              c_q;
        logic [TIME_W-1:0] t_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '0;
                t_q <= '0;
            end else if (take[g]) begin
                c_q      <= cmd_in;
                c_q.keep <= cmd_in.keep & lock_en;
                t_q      <= time_in;
            end
        end

        assign fire[g]     = valid_q[g] && cmp_en && (t_q == (c_q.use_t2 ? timer2 : timer1));
        assign keep_v[g]   = c_q.keep;
        assign slot_cmd[g] = c_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   valid_q <= '0;
        else if (clr) valid_q <= '0;
        else          valid_q <= (valid_q & ~retire) | take;
    end

    // R9
    table_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_q == '0));
    // R4
    one_shot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|retire) |=> ((valid_q & $past(retire)) == '0));
    // R4
    locked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(fire & keep_v)) && !clr) |=> ((valid_q & $past(fire & keep_v)) == $past(fire & keep_v)));
    // R10
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && full && !clr && !(|fire)) |=> $stable(valid_q));
endmodule

// File: rtl/evsched_act.sv
module evsched_act
    import evsched_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_en,
    input  logic [N_SLOTS-1:0]  fire,
    input  cmd_t                slot_cmd [N_SLOTS],
    output logic [PIN_CNT-1:0]  set_m,
    output logic [PIN_CNT-1:0]  clr_m,
    output logic [STAT_W-1:0]   ev_bits,
    output logic                irq_pin_o,
    output logic                irq_other_o,
    output logic [SWT_CNT-1:0]  swt_o,
    output logic                t2_reset_o,
    output logic                adc_start_o
);
    logic [PIN_CNT-1:0] m, pin_ev;
    logic               ip_d, io_d, t2_d, adc_d;
    logic [SWT_CNT-1:0] swt_d;

    // Walk from the top slot down so the lowest slot writes last and wins.
    always_comb begin
        set_m  = '0;
        clr_m  = '0;
        pin_ev = '0;
        m      = '0;
        ip_d   = 1'b0;
        io_d   = 1'b0;
        t2_d   = 1'b0;
        adc_d  = 1'b0;
        swt_d  = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (fire[i]) begin
                m = pin_mask(slot_cmd[i].chan);
                if (slot_cmd[i].drive_hi) begin
                    set_m = set_m | m;
                    clr_m = clr_m & ~m;
                end else begin
                    clr_m = clr_m | m;
                    set_m = set_m & ~m;
                end
                pin_ev = pin_ev | m;
                if (slot_cmd[i].want_irq) begin
                    if (slot_cmd[i].chan[3]) io_d = 1'b1;
                    else                     ip_d = 1'b1;
                end
                if (slot_cmd[i].chan[3:2] == 2'b10) swt_d[slot_cmd[i].chan[1:0]] = 1'b1;
                if (slot_cmd[i].chan == 4'hE) t2_d = 1'b1;
                if (slot_cmd[i].chan == 4'hF) adc_d = 1'b1;
            end
        end
    end

    assign ev_bits = {adc_d, t2_d, pin_ev};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pin_o   <= 1'b0;
            irq_other_o <= 1'b0;
            swt_o       <= '0;
            t2_reset_o  <= 1'b0;
            adc_start_o <= 1'b0;
        end else begin
            irq_pin_o   <= ip_d;
            irq_other_o <= io_d;
            swt_o       <= swt_d;
            t2_reset_o  <= t2_d;
            adc_start_o <= adc_d;
        end
    end

    // R5
    irq_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin_o || irq_other_o) |-> $past(cmp_en));
    // R3
    action_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|swt_o) || t2_reset_o || adc_start_o) |-> $past(cmp_en));
endmodule

// File: rtl/evsched_stat.sv
module evsched_stat
    import evsched_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  logic [STAT_W-1:0]  wdata,
    input  logic [PIN_CNT-1:0] set_m,
    input  logic [PIN_CNT-1:0] clr_m,
    input  logic [STAT_W-1:0]  ev_bits,
    output logic [PIN_CNT-1:0] pins_o,
    output logic [STAT_W-1:0]  status_o
);
    logic [PIN_CNT-1:0] pins_q, pins_d, pin_base;
    logic [STAT_W-1:0]  stat_q, stat_d, st_base;

    always_comb begin
        pin_base = stat_wr ? wdata[PIN_CNT-1:0] : pins_q;
        pins_d   = (pin_base & ~clr_m) | set_m;
        if (stat_wr)      st_base = wdata;
        else if (stat_rd) st_base = '0;
        else              st_base = stat_q;
        stat_d = st_base | ev_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
            stat_q <= '0;
        end else begin
            pins_q <= pins_d;
            stat_q <= stat_d;
        end
    end

    assign pins_o   = pins_q;
    assign status_o = stat_q;

    // R8
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((stat_q & $past(wdata)) == $past(wdata)));
    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_wr) |=> (stat_q == $past(ev_bits)));
    // R2
    pin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pins_q) |-> $past(stat_wr || (|set_m) || (|clr_m)));
endmodule

// File: rtl/evsched_top.sv
module evsched_top
    import evsched_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int TIME_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              time_we,
    input  logic [TIME_W-1:0] time_word,
    input  logic              lock_en,
    input  logic              tbl_clr,
    input  logic              cmp_en,
    input  logic [TIME_W-1:0] timer1,
    input  logic [TIME_W-1:0] timer2,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    output logic [5:0]        pins_o,
    output logic              irq_pin_o,
    output logic              irq_other_o,
    output logic [3:0]        swt_o,
    output logic              t2_reset_o,
    output logic              adc_start_o,
    output logic              full_o,
    output logic [7:0]        status_o
);
    logic               commit;
    cmd_t               held_cmd;
    logic [N_SLOTS-1:0] fire;
    cmd_t               slot_cmd [N_SLOTS];
    logic [PIN_CNT-1:0] set_m, clr_m;
    logic [STAT_W-1:0]  ev_bits;

    evsched_wr u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_byte (cmd_byte),
        .time_we  (time_we),
        .commit   (commit),
        .held_cmd (held_cmd)
    );

    evsched_table #(.N_SLOTS(N_SLOTS), .TIME_W(TIME_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .cmd_in   (held_cmd),
        .time_in  (time_word),
        .lock_en  (lock_en),
        .clr      (tbl_clr),
        .cmp_en   (cmp_en),
        .timer1   (timer1),
        .timer2   (timer2),
        .fire     (fire),
        .slot_cmd (slot_cmd),
        .full     (full_o)
    );

    evsched_act #(.N_SLOTS(N_SLOTS)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_en      (cmp_en),
        .fire        (fire),
        .slot_cmd    (slot_cmd),
        .set_m       (set_m),
        .clr_m       (clr_m),
        .ev_bits     (ev_bits),
        .irq_pin_o   (irq_pin_o),
        .irq_other_o (irq_other_o),
        .swt_o       (swt_o),
        .t2_reset_o  (t2_reset_o),
        .adc_start_o (adc_start_o)
    );

    evsched_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_rd  (stat_rd),
        .stat_wr  (stat_wr),
        .wdata    (stat_wdata),
        .set_m    (set_m),
        .clr_m    (clr_m),
        .ev_bits  (ev_bits),
        .pins_o   (pins_o),
        .status_o (status_o)
    );
endmodule

// File: tb/tb_evsched_top.sv
`timescale 1ns/1ps
module tb_evsched_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_we = 0, time_we = 0, lock_en = 0, tbl_clr = 0, cmp_en = 0;
    logic        stat_rd = 0, stat_wr = 0;
    logic [7:0]  cmd_byte = 0, stat_wdata = 0;
    logic [15:0] time_word = 0, timer1 = 0, timer2 = 0;
    logic [5:0]  pins_o;
    logic        irq_pin_o, irq_other_o, t2_reset_o, adc_start_o, full_o;
    logic [3:0]  swt_o;
    logic [7:0]  status_o;

    int checks = 0;
    int errors = 0;

    evsched_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .time_we(time_we), .time_word(time_word), .lock_en(lock_en),
        .tbl_clr(tbl_clr), .cmp_en(cmp_en), .timer1(timer1), .timer2(timer2),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .pins_o(pins_o), .irq_pin_o(irq_pin_o), .irq_other_o(irq_other_o),
        .swt_o(swt_o), .t2_reset_o(t2_reset_o), .adc_start_o(adc_start_o),
        .full_o(full_o), .status_o(status_o)
    );

    // ---------------- behavioural reference model ----------------
    bit        mv [8];
    bit        mk [8];
    bit [7:0]  mc [8];
    bit [15:0] mt [8];
    bit        mpend;
    bit [7:0]  mpc;
    bit [5:0]  e_pins;
    bit [7:0]  e_stat;
    bit        e_ip, e_io, e_t2, e_adc, e_full;
    bit [3:0]  e_swt;

    function automatic bit [5:0] pins_of(bit [3:0] c);
        if (c < 6)  return 6'd1 << c;
        if (c == 6) return 6'h03;
        if (c == 7) return 6'h0C;
        return 6'h00;
    endfunction

    always @(posedge clk) begin : model
        bit        oldv [8];
        bit        fired;
        bit        fullb, done;
        bit [5:0]  s, k, pe, msk;
        bit [3:0]  c;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin mv[i] = 0; mk[i] = 0; end
            mpend = 0; e_pins = 0; e_stat = 0; e_ip = 0; e_io = 0;
            e_t2 = 0; e_adc = 0; e_swt = 0; e_full = 0;
        end else begin
            fullb = 1;
            for (int i = 0; i < 8; i++) begin
                oldv[i] = mv[i];
                if (!mv[i]) fullb = 0;
            end
            s = 0; k = 0; pe = 0;
            e_ip = 0; e_io = 0; e_t2 = 0; e_adc = 0; e_swt = 0;
            for (int i = 7; i >= 0; i--) begin
                fired = mv[i] && cmp_en && (mt[i] == (mc[i][6] ? timer2 : timer1));
                if (fired) begin
                    c = mc[i][3:0];
                    msk = pins_of(c);
                    if (mc[i][5]) begin s = s | msk; k = k & ~msk; end
                    else          begin k = k | msk; s = s & ~msk; end
                    pe = pe | msk;
                    if (mc[i][4]) begin
                        if (c >= 8) e_io = 1; else e_ip = 1;
                    end
                    if (c >= 8 && c <= 11) e_swt[c - 8] = 1;
                    if (c == 14) e_t2 = 1;
                    if (c == 15) e_adc = 1;
                    if (!mk[i]) mv[i] = 0;
                end
            end
            if (stat_wr) e_pins = stat_wdata[5:0];
            e_pins = (e_pins & ~k) | s;
            if (stat_wr)      e_stat = stat_wdata;
            else if (stat_rd) e_stat = 0;
            e_stat = e_stat | {e_adc, e_t2, pe};
            if (mpend && time_we && !fullb && !tbl_clr) begin
                done = 0;
                for (int i = 0; i < 8; i++) begin
                    if (!oldv[i] && !done) begin
                        mv[i] = 1; mc[i] = mpc; mk[i] = mpc[7] & lock_en;
                        mt[i] = time_word; done = 1;
                    end
                end
            end
            if (tbl_clr) for (int i = 0; i < 8; i++) mv[i] = 0;
            if (cmd_we) begin mpend = 1; mpc = cmd_byte; end
            else if (mpend && time_we) mpend = 0;
            e_full = 1;
            for (int i = 0; i < 8; i++) if (!mv[i]) e_full = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pins_o == e_pins, "R2 pins", pins_o, e_pins);
            chk(irq_pin_o == e_ip && irq_other_o == e_io, "R5 irq",
                {irq_pin_o, irq_other_o}, {e_ip, e_io});
            chk(swt_o == e_swt && t2_reset_o == e_t2 && adc_start_o == e_adc, "R3 actions",
                {swt_o, t2_reset_o, adc_start_o}, {e_swt, e_t2, e_adc});
            chk(full_o == e_full, "R10 full", full_o, e_full);
            chk(status_o == e_stat, "R6 status", status_o, e_stat);
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] c, input logic [15:0] t);
        cyc(); cmd_we = 1; cmd_byte = c;
        cyc(); cmd_we = 0; time_we = 1; time_word = t;
        cyc(); time_we = 0;
    endtask

    task automatic fire(input logic [15:0] a, input logic [15:0] b);
        cyc(); timer1 = a; timer2 = b; cmp_en = 1;
        cyc(); cmp_en = 0;
    endtask

    task automatic rd();
        cyc(); stat_rd = 1;
        cyc(); stat_rd = 0;
    endtask

    task automatic swr(input logic [7:0] v);
        cyc(); stat_wr = 1; stat_wdata = v;
        cyc(); stat_wr = 0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk(pins_o == 0, "R2 reset pins", pins_o, 0);
        chk(status_o == 0, "R6 reset status", status_o, 0);
        chk(full_o == 0, "R10 reset full", full_o, 0);

        // R1: field decode and timer select
        wr(8'h30, 16'd5);
        wr(8'h65, 16'd6);
        fire(16'd5, 16'd0);
        chk(pins_o == 6'h01, "R1 set pin0 on timer1", pins_o, 6'h01);
        chk(irq_pin_o == 1, "R5 pin irq", irq_pin_o, 1);
        fire(16'd9, 16'd6);
        chk(pins_o == 6'h21, "R1 timer2 select", pins_o, 6'h21);
        chk(irq_pin_o == 0, "R5 no irq bit", irq_pin_o, 0);

        // R2: paired channels
        wr(8'h26, 16'd100);
        wr(8'h27, 16'd100);
        fire(16'd100, 16'd0);
        chk(pins_o == 6'h2F, "R2 paired set", pins_o, 6'h2F);
        wr(8'h06, 16'd101);
        fire(16'd101, 16'd0);
        chk(pins_o == 6'h2C, "R2 pair clear", pins_o, 6'h2C);
        chk(status_o == 8'h2F, "R6 pin events", status_o, 8'h2F);
        rd();
        chk(status_o == 0, "R7 read clears", status_o, 0);

        // R3 / R5: non-pin codes
        wr(8'h19, 16'd200);
        wr(8'h1E, 16'd200);
        wr(8'h0F, 16'd200);
        wr(8'h1C, 16'd200);
        fire(16'd200, 16'd0);
        chk(swt_o == 4'b0010, "R3 soft timer 1", swt_o, 4'b0010);
        chk(t2_reset_o == 1 && adc_start_o == 1, "R3 t2 reset and adc",
            {t2_reset_o, adc_start_o}, 2'b11);
        chk(irq_other_o == 1 && irq_pin_o == 0, "R5 other irq",
            {irq_pin_o, irq_other_o}, 2'b01);
        chk(pins_o == 6'h2C, "R3 codes leave pins", pins_o, 6'h2C);
        chk(status_o == 8'hC0, "R6 t2/adc bits", status_o, 8'hC0);

        // R4: lock only with lock_en
        rd();
        lock_en = 1;
        wr(8'hA1, 16'd300);
        lock_en = 0;
        wr(8'hA4, 16'd300);
        fire(16'd300, 16'd0);
        chk(pins_o == 6'h3E, "R4 first fire", pins_o, 6'h3E);
        swr(8'h00);
        chk(pins_o == 0 && status_o == 0, "R8 preset zero", {status_o, pins_o}, 0);
        chk(irq_pin_o == 0 && irq_other_o == 0, "R8 preset no irq",
            {irq_pin_o, irq_other_o}, 0);
        fire(16'd300, 16'd0);
        chk(pins_o == 6'h02, "R4 locked refires, unlocked gone", pins_o, 6'h02);

        // R12: lowest slot wins on conflict
        wr(8'h23, 16'd400);
        wr(8'h03, 16'd400);
        fire(16'd400, 16'd0);
        chk(pins_o == 6'h0A, "R12 low slot set wins", pins_o, 6'h0A);
        wr(8'h03, 16'd401);
        wr(8'h23, 16'd401);
        fire(16'd401, 16'd0);
        chk(pins_o == 6'h02, "R12 low slot clear wins", pins_o, 6'h02);

        // R11: time word alone, command alone
        cyc(); time_we = 1; time_word = 16'd500;
        cyc(); time_we = 0;
        cyc(); cmd_we = 1; cmd_byte = 8'h24;
        cyc(); cmd_we = 0;
        fire(16'd500, 16'd0);
        chk(pins_o == 6'h02, "R11 nothing committed", pins_o, 6'h02);
        cyc(); time_we = 1; time_word = 16'd500;
        cyc(); time_we = 0;
        fire(16'd500, 16'd0);
        chk(pins_o == 6'h12, "R11 commit on time word", pins_o, 6'h12);

        // R10 / R9: fill, overflow, clear
        for (int i = 0; i < 7; i++) wr(8'h00, 16'(600 + i));
        chk(full_o == 1, "R10 full after 8", full_o, 1);
        wr(8'h25, 16'd700);
        fire(16'd700, 16'd0);
        chk(pins_o == 6'h12, "R10 write while full dropped", pins_o, 6'h12);
        cyc(); tbl_clr = 1;
        cyc(); tbl_clr = 0;
        chk(full_o == 0, "R9 clear empties", full_o, 0);
        rd();
        fire(16'd300, 16'd0);
        chk(status_o == 0, "R9 locked entry removed", status_o, 0);
        fire(16'd600, 16'd0);
        chk(status_o == 0, "R9 plain entry removed", status_o, 0);
        swr(8'h85);
        chk(pins_o == 6'h05 && status_o == 8'h85, "R8 preset load",
            {status_o, pins_o}, {8'h85, 6'h05});

        repeat (3) cyc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule